// File: doc/BRIEF.md
# Configuration Lock Key Sequencer

This block sits behind a GPIO port's configuration lock register. It watches the writes that are aimed at that register and tracks a three-step key handshake on the key bit, which sits just above the pin mask. All three steps must be full-word writes that carry the same pin mask. The key bit must be written 1, then 0, then 1.

When the handshake completes, the key flag is set and stays set until reset. The pin mask is then frozen, and the freeze vector that goes to the port's configuration register file shows the mask. Each set bit of that vector stops updates to that pin's mode, output type, speed, pull and alternate-function fields. Any departure from the handshake drops the attempt.

While the register is unlocked, the mask can be rewritten freely.

Top module: `cfg_lock_seq`

## Requirements
- R1: After reset the read data is all zero and the freeze vector is all zero.
- R2: While the key flag is clear, every write to the register (word or not) loads bits PINS-1:0 of the write data into the pin mask, and the mask reads back on bits PINS-1:0 in the cycle after the write.
- R3: Three consecutive full-word writes with bit PINS (the key bit, bit 16 by default) equal to 1, 0, 1 and identical mask bits set the key flag. The flag reads back on bit PINS. In the cycle after the third write, the freeze vector equals the mask. Before the flag is set, the freeze vector is zero.
- R4: A write with the full-word indication low drops any attempt in progress. A lock then needs three fresh full-word writes.
- R5: A full-word write whose mask differs from the stored mask drops the attempt. If that write carries key 1, it counts as a new first step with its own mask.
- R6: A key-1 word write always restarts the handshake at step two. A key-0 word write that does not directly follow a key-1 step drops the attempt. So 1,1,0,1 locks, while 1,0,0,1 does not.
- R7: Once the key flag is set, no write of any kind changes the read data or the freeze vector until reset, and reset clears both.
- R8: Read data bits DW-1:PINS+1 always read 0, whatever was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset (system or peripheral reset) |
| wr_en | input | 1 | One-cycle strobe: a write to the lock register |
| wr_word | input | 1 | The write is a full 32-bit access |
| wr_data | input | DW | Write data; bit PINS is the key, bits PINS-1:0 the pin mask |
| rd_data | output | DW | Lock register read value: key flag on bit PINS, mask below |
| freeze | output | PINS | Per-pin freeze to the configuration register file |

## Verification
The bench sweeps every pattern of key values and word/non-word flags over four writes after reset. It checks the lock state against a sliding three-write window rule, which separates real handshakes from near misses such as 1,0,0,1 and 1,1,0,1. Directed mask-change sequences separate a plain abort from an abort that restarts the handshake with a new mask. After a lock, all-ones and all-zeros writes of both widths show that the register and the freeze vector cannot move until reset.

// File: rtl/cfg_lock_seq.sv
module cfg_lock_seq #(
  parameter int PINS = 16,
  parameter int DW   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            wr_word,
  input  logic [DW-1:0]   wr_data,
  output logic [DW-1:0]   rd_data,
  output logic [PINS-1:0] freeze
);
  localparam int KEY = PINS;

  typedef enum logic [1:0] {IDLE, ARMED, GOT0} step_t;

  step_t           st;
  logic            locked;
  logic [PINS-1:0] mask;

  wire key  = wr_data[KEY];
  wire same = (wr_data[PINS-1:0] == mask);
  wire unused_hi = ^wr_data[DW-1:KEY+1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= IDLE;
      locked <= 1'b0;
      mask   <= '0;
    end else if (wr_en && !locked) begin
      mask <= wr_data[PINS-1:0];
      if (!wr_word)                    st <= IDLE;
      else if (st == GOT0 && key && same) begin
        locked <= 1'b1;
        st     <= IDLE;
      end
      else if (key)                    st <= ARMED;
      else if (st == ARMED && same)    st <= GOT0;
      else                             st <= IDLE;
    end
  end

  assign rd_data = {{(DW-KEY-1){1'b0}}, locked, mask};
  assign freeze  = {PINS{locked}} & mask;
endmodule

// File: rtl/cfg_lock_seq_chk.sv
module cfg_lock_seq_chk #(
  parameter int PINS = 16,
  parameter int DW   = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic            wr_word,
  input logic [DW-1:0]   wr_data,
  input logic [DW-1:0]   rd_data,
  input logic [PINS-1:0] freeze
);
  localparam int KEY = PINS;

  a_r2_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rd_data[KEY]) |=> rd_data[PINS-1:0] == $past(wr_data[PINS-1:0]));

  a_r3_lock_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_data[KEY]) |-> $past(wr_en && wr_word && wr_data[KEY])
                             && $past(wr_data[PINS-1:0]) == freeze);

  a_r3_no_early_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[KEY] |-> freeze == '0);

  a_r4_nonword_no_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_word && !rd_data[KEY]) |=> !rd_data[KEY]);

  a_r7_frozen_stable: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[KEY] |=> $stable(rd_data) && $stable(freeze));

  a_r8_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[DW-1:KEY+1] == '0);
endmodule

bind cfg_lock_seq cfg_lock_seq_chk #(.PINS(PINS), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_word(wr_word),
  .wr_data(wr_data), .rd_data(rd_data), .freeze(freeze)
);

// File: tb/cfg_lock_seq_test.sv
module cfg_lock_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_word = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [15:0] freeze;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  cfg_lock_seq uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_word(wr_word),
                    .wr_data(wr_data), .rd_data(rd_data), .freeze(freeze));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; wr_en = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic wr(input logic word, input logic key, input logic [15:0] m, input logic [14:0] hi = '0);
    @(negedge clk);
    wr_en = 1'b1; wr_word = word; wr_data = {hi, key, m};
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic expect_lock(input string req, input logic lk, input logic [15:0] m);
    check(req, rd_data, {15'b0, lk, m});
    check(req, {16'b0, freeze}, {16'b0, lk ? m : 16'h0});
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    expect_lock("R1 reset", 1'b0, 16'h0);

    // R3 R4 R6: every 4-write key/width pattern, window rule
    for (int p = 0; p < 16; p++) begin
      for (int w = 0; w < 16; w++) begin
        logic [15:0] m;
        logic lk;
        m = {p[3:0], w[3:0], 8'hA5};
        lk = 1'b0;
        do_reset();
        for (int i = 0; i < 4; i++) begin
          wr(w[i], p[i], m);
          if (i >= 2 && w[i] && w[i-1] && w[i-2] && p[i] && !p[i-1] && p[i-2]) lk = 1'b1;
        end
        expect_lock(lk ? "R3 window lock" : (w != 15 ? "R4 nonword abort" : "R6 key order"), lk, m);
      end
    end

    // R6 directed
    do_reset();
    wr(1, 1, 16'h0F0F); wr(1, 1, 16'h0F0F); wr(1, 0, 16'h0F0F); wr(1, 1, 16'h0F0F);
    expect_lock("R6 1101 locks", 1'b1, 16'h0F0F);
    do_reset();
    wr(1, 1, 16'h0F0F); wr(1, 0, 16'h0F0F); wr(1, 0, 16'h0F0F); wr(1, 1, 16'h0F0F);
    expect_lock("R6 1001 no lock", 1'b0, 16'h0F0F);

    // R5 mask change on every bit position
    for (int b = 0; b < 16; b++) begin
      logic [15:0] m2;
      m2 = 16'h3C96 ^ (16'h1 << b);
      do_reset();
      wr(1, 1, 16'h3C96); wr(1, 0, m2); wr(1, 1, m2);
      expect_lock("R5 abort on changed mask", 1'b0, m2);
      do_reset();
      wr(1, 1, 16'h3C96); wr(1, 0, 16'h3C96); wr(1, 1, m2);
      expect_lock("R5 restart not lock", 1'b0, m2);
      wr(1, 0, m2); wr(1, 1, m2);
      expect_lock("R5 restart completes", 1'b1, m2);
    end

    // R2 mask writes, R8 reserved bits
    do_reset();
    wr(0, 0, 16'hBEEF, 15'h7FFF);
    expect_lock("R2 nonword mask write", 1'b0, 16'hBEEF);
    wr(1, 1, 16'hFFFF, 15'h7FFF);
    check("R8 reserved zero", {16'b0, rd_data[31:16]}, 32'h0);
    expect_lock("R2 word mask write", 1'b0, 16'hFFFF);

    // R7 immunity after lock, then reset clears
    do_reset();
    wr(1, 1, 16'h8001); wr(1, 0, 16'h8001); wr(1, 1, 16'h8001);
    expect_lock("R3 lock", 1'b1, 16'h8001);
    wr(1, 0, 16'h0000); wr(0, 1, 16'hFFFF, 15'h7FFF); wr(1, 1, 16'h1234);
    expect_lock("R7 frozen", 1'b1, 16'h8001);
    check("R8 after lock", {16'b0, rd_data[31:16]}, 32'h1);
    do_reset();
    expect_lock("R7 reset clears", 1'b0, 16'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule